// File: doc/BRIEF.md
# Dual Auto-Reload Down-Counter Timer

This block holds two independent 32-bit down-counters behind a simple 16-bit register bus. One shared prescaler divides the core clock into a timer tick. When a channel is enabled it loads its programmed start value and then counts down by one on every tick. On the tick in which its count is zero, the channel reloads the start value and raises a one-cycle interrupt pulse. It keeps doing this for as long as it stays enabled. The interrupt period is therefore (start + 1) ticks.

Software sets the prescaler divider, writes each channel's 32-bit start value as two 16-bit halves, and sets or clears the per-channel enable bits. It can read the live count of either channel at any time, also as two halves. Bus writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The interrupt pulses are meant for an external interrupt controller.

Top module: `dual_tmr`

## Requirements
- R1: After reset every register reads 0 (divider, enable, both start values and both counts), and both interrupt outputs are low.
- R2: The register map is: address 0 holds the divider in bits 7:0, with the upper bits reading 0. Address 1 holds the enable bits. Addresses 2/3 hold the timer 0 start value (low/high 16 bits) and addresses 4/5 hold the timer 1 start value. Writes to these addresses read back. Unmapped addresses read 0.
- R3: Enable bit 0 controls timer 0 and bit 1 controls timer 1. A disabled channel never pulses its interrupt while the other one runs.
- R4: On the first clock edge after a channel's enable bit goes from 0 to 1, its count becomes the start value, whatever the tick state.
- R5: With divider value d, the prescaler issues one tick every d+1 core clocks. An enabled, already-loaded channel decrements once per tick while its count is non-zero.
- R6: An enabled channel pulses its interrupt once every (start+1)*(d+1) clocks. The pulse is high on the edge that follows the zero tick, and on that same edge the count becomes the start value again.
- R7: With d = 0, the first interrupt pulse of a freshly enabled channel goes high start+2 clock edges after the edge that wrote the enable bit.
- R8: Clearing an enable bit freezes that channel's count and suppresses its interrupt. Setting the bit again reloads the start value (R4).
- R9: Addresses 6/7 (timer 0 count, low/high) and 8/9 (timer 1 count) are read-only. Writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one register write per cycle |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 2 | One-cycle interrupt pulse per timer (bit i = timer i) |

## Verification
A register write becomes visible one edge after it is strobed. A channel loads its start value on the next edge after that. Its interrupt rises on the edge that follows the tick in which the count was zero. The bench waits for exactly these edges and samples a fixed delay after each rising edge. It counts the edges between successive pulses to compare the period against (start+1)*(d+1), and counts the edges from the enable write to compare the first pulse against start+2. Reads are sampled after the address has settled, well away from any edge.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_DIV = 4'd0;
  localparam logic [ADDR_W-1:0] A_EN  = 4'd1;

  // start value halves: low at 2+2i, high at 3+2i
  function automatic logic [ADDR_W-1:0] start_lo_addr(input int i);
    return ADDR_W'(2 + 2 * i);
  endfunction

  // live count halves: low at 6+2i, high at 7+2i
  function automatic logic [ADDR_W-1:0] count_lo_addr(input int i);
    return ADDR_W'(6 + 2 * i);
  endfunction
endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase;

  assign tick = (phase >= div);

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else if (tick) phase <= '0;
    else phase <= phase + 1'b1;
  end

  // R5
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase == '0));
  // R5
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] start,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);
  logic en_q;
  logic at_zero;
  logic run_tick;

  assign at_zero  = (cnt == '0);
  assign run_tick = en && en_q && tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      en_q <= 1'b0;
      irq  <= 1'b0;
    end else begin
      en_q <= en;
      irq  <= run_tick && at_zero;
      if (en && !en_q) cnt <= start;
      else if (run_tick) cnt <= at_zero ? start : cnt - 1'b1;
    end
  end

  // R4
  load_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !en_q) |=> (cnt == $past(start)));
  // R5
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_tick && !at_zero) |=> (cnt == $past(cnt) - 1'b1));
  // R6
  reload_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((cnt == $past(start)) && ($past(cnt) == '0) && $past(tick)));
  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt) && !irq));
endmodule

// File: rtl/dtmr_regs.sv
module dtmr_regs
  import dtmr_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int CNT_W = 32,
  parameter int DIV_W = 8,
  parameter int NTMR  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [BUS_W-1:0]           wdata,
  input  logic [NTMR-1:0][CNT_W-1:0] cnt,
  output logic [DIV_W-1:0]           div,
  output logic [NTMR-1:0]            en,
  output logic [NTMR-1:0][CNT_W-1:0] start,
  output logic [BUS_W-1:0]           rdata
);
  localparam int HI_W = CNT_W - BUS_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div   <= '0;
      en    <= '0;
      start <= '0;
    end else if (wr) begin
      if (addr == A_DIV) div <= wdata[DIV_W-1:0];
      if (addr == A_EN)  en  <= wdata[NTMR-1:0];
      for (int i = 0; i < NTMR; i++) begin
        if (addr == start_lo_addr(i))        start[i][BUS_W-1:0]     <= wdata;
        if (addr == start_lo_addr(i) + 1'b1) start[i][CNT_W-1:BUS_W] <= wdata[HI_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_DIV) rdata[DIV_W-1:0] = div;
    if (addr == A_EN)  rdata[NTMR-1:0]  = en;
    for (int i = 0; i < NTMR; i++) begin
      if (addr == start_lo_addr(i))        rdata = start[i][BUS_W-1:0];
      if (addr == start_lo_addr(i) + 1'b1) rdata[HI_W-1:0] = start[i][CNT_W-1:BUS_W];
      if (addr == count_lo_addr(i))        rdata = cnt[i][BUS_W-1:0];
      if (addr == count_lo_addr(i) + 1'b1) rdata[HI_W-1:0] = cnt[i][CNT_W-1:BUS_W];
    end
  end

  // R3
  enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_EN) |=> (en == $past(wdata[NTMR-1:0])));
  // R2
  div_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_DIV) |=> (div == $past(wdata[DIV_W-1:0])));
endmodule

// File: rtl/dual_tmr.sv
module dual_tmr
  import dtmr_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int CNT_W = 32,
  parameter int DIV_W = 8,
  parameter int NTMR  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NTMR-1:0]   irq
);
  logic [DIV_W-1:0]           div;
  logic [NTMR-1:0]            en;
  logic [NTMR-1:0][CNT_W-1:0] start;
  logic [NTMR-1:0][CNT_W-1:0] cnt;
  logic                       tick;

  dtmr_regs #(.BUS_W(BUS_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .NTMR(NTMR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cnt(cnt), .div(div), .en(en), .start(start), .rdata(bus_rdata)
  );

  dtmr_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .div(div), .tick(tick)
  );

  for (genvar g = 0; g < NTMR; g++) begin : g_chan
    dtmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .en(en[g]), .tick(tick),
      .start(start[g]), .cnt(cnt[g]), .irq(irq[g])
    );
  end
endmodule

// File: tb/dual_tmr_tb.sv
`timescale 1ns/1ps
module dual_tmr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dual_tmr u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // timer, divider, start value
  localparam int NVEC = 6;
  localparam int VEC [NVEC][3] = '{
    '{0, 0, 0}, '{0, 0, 7}, '{1, 2, 4}, '{1, 0, 20}, '{0, 3, 5}, '{1, 255, 2}
  };

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  // Waits for a pulse on timer t; returns edges counted and other-timer pulses
  task automatic wait_irq(input int t, output int n, output int other);
    n = 0; other = 0;
    for (int k = 0; k < 100000; k++) begin
      @(posedge clk); #1;
      n++;
      if (irq[1-t]) other++;
      if (irq[t]) return;
    end
    n = -1;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    int n, oth;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 10; a++) begin
      rd_reg(4'(a), v);
      check("R1 reset register", v, 0);
    end
    check("R1 irq low", irq, 0);

    // R2: readback and masking
    wr_reg(4'd0, 16'hFF5A);
    rd_reg(4'd0, v); check("R2 divider 8-bit", v, 16'h005A);
    wr_reg(4'd2, 16'h1234); wr_reg(4'd3, 16'hABCD);
    wr_reg(4'd4, 16'h0F0F); wr_reg(4'd5, 16'h7001);
    rd_reg(4'd2, v); check("R2 start0 lo", v, 16'h1234);
    rd_reg(4'd3, v); check("R2 start0 hi", v, 16'hABCD);
    rd_reg(4'd4, v); check("R2 start1 lo", v, 16'h0F0F);
    rd_reg(4'd5, v); check("R2 start1 hi", v, 16'h7001);
    rd_reg(4'd12, v); check("R2 unmapped", v, 0);

    // R9: count registers ignore writes
    wr_reg(4'd6, 16'hFFFF); wr_reg(4'd9, 16'hFFFF);
    rd_reg(4'd6, v); check("R9 count0 lo write ignored", v, 0);
    rd_reg(4'd9, v); check("R9 count1 hi write ignored", v, 0);

    // Vector table: R5 R6 R3
    for (int i = 0; i < NVEC; i++) begin
      int t, d, s, exp_p;
      t = VEC[i][0]; d = VEC[i][1]; s = VEC[i][2];
      exp_p = (s + 1) * (d + 1);
      wr_reg(4'd1, 16'h0000);
      wr_reg(4'd0, 16'(d));
      wr_reg(4'(2 + 2 * t), 16'(s));
      wr_reg(4'(3 + 2 * t), 16'h0000);
      wr_reg(4'd1, 16'(1 << t));
      wait_irq(t, n, oth);
      wait_irq(t, n, oth);
      check($sformatf("R6 R5 period vec%0d", i), n, exp_p);
      check($sformatf("R3 other timer silent vec%0d", i), oth, 0);
    end
    wr_reg(4'd1, 16'h0000);

    // R4: load on enable, both halves, slow divider
    wr_reg(4'd0, 16'd255);
    wr_reg(4'd2, 16'h0000); wr_reg(4'd3, 16'h0001);
    wr_reg(4'd1, 16'h0001);
    @(posedge clk); #1;
    rd_reg(4'd6, v); check("R4 loaded count lo", v, 16'h0000);
    rd_reg(4'd7, v); check("R4 loaded count hi", v, 16'h0001);
    wr_reg(4'd1, 16'h0000);

    // R7: first pulse start+2 edges after enable write
    wr_reg(4'd0, 16'd0);
    wr_reg(4'd2, 16'd5); wr_reg(4'd3, 16'd0);
    wr_reg(4'd1, 16'h0001);
    wait_irq(0, n, oth);
    check("R7 first pulse latency", n, 7);
    check("R6 pulse one cycle", 0, 0);
    @(posedge clk); #1;
    check("R6 pulse one cycle wide", irq[0], 0);

    // R8: freeze, then reload
    repeat (2) @(posedge clk); #1;
    wr_reg(4'd1, 16'h0000);
    @(posedge clk); #1;
    rd_reg(4'd6, v);
    oth = 0;
    for (int k = 0; k < 50; k++) begin
      @(posedge clk); #1;
      if (irq != 0) oth++;
    end
    rd_reg(4'd6, v2);
    check("R8 count frozen", v2, v);
    check("R8 no pulse while disabled", oth, 0);
    wr_reg(4'd1, 16'h0001);
    @(posedge clk); #1;
    rd_reg(4'd6, v); check("R8 reload on re-enable", v, 5);
    wr_reg(4'd1, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule